// File: doc/BRIEF.md
# Interrupt Recognition and Entry Sequencer

This block is the interrupt front end of a small 8-bit accumulator processor. It watches a level-sensitive maskable request and a falling-edge non-maskable request. It decides at instruction-dependent poll points whether an interrupt is taken. When one is taken, it steps the seven-cycle entry that the processor runs in place of the next instruction. The core reports its cycle status: a strobe on the last cycle of every instruction, a flag for branch instructions, and a strobe on a branch's second cycle. On the last cycle of the matching instructions it also reports mask-set, mask-clear and return-from-interrupt events, together with the mask value that the return restores.

When an interrupt is taken, the cycle after the poll is the opcode fetch of the next instruction. The block asserts an override so that the core loads a break opcode in place of the fetched byte. The later cycles are a dummy read and three stack pushes: return-address high byte, then low byte, then status. Two vector reads follow, and the block drives the vector address for them. The block keeps its own copy of the interrupt mask. That copy follows the core's one-instruction pipelining lag for set and clear, and it follows the early restore done by the return instruction.

Top module: `irq_entry_ctl`

## Requirements
- R1: After reset all outputs are low, no non-maskable request is pending, no entry is running and the mask is set, so a low `irq_n` starts no entry until the mask is cleared.
- R2: When an interrupt is taken at the poll of an instruction whose `op_last` cycle is cycle N, `opc_force` is high in cycle N+1 only. It is followed by one dummy cycle, then `push_pch`, `push_pcl` and `push_stat`, each high for one cycle in that order, then two vector cycles. The entry lasts seven cycles in total, and at most one of these strobes is high in any cycle.
- R3: For an instruction with `op_branch` high, the only poll is the cycle where `br_poll` is high. If the poll finds a request pending, the entry starts after that branch's `op_last` cycle. A request that appears after `br_poll` is not taken at that branch's end. It is taken at the end of the next instruction if it is still pending.
- R4: A high-to-low transition of `nmi_n` sets a pending flag that stays set until it is serviced. Holding `nmi_n` low causes exactly one entry. When both requests are pending at a poll, the non-maskable vector is used.
- R5: A low `irq_n` starts no entry while the mask is set.
- R6: `vec_en` is high in the last two entry cycles. `vec_addr` is 0xFFFA then 0xFFFB for a non-maskable entry, and 0xFFFE then 0xFFFF otherwise, and it is 0 while `vec_en` is low. The vector is chosen in the first vector cycle from the pending non-maskable flag, so an edge that arrives two or more cycles earlier in the entry redirects it.
- R7: `set_iflag` is high in the first vector cycle, and the mask is set from the next cycle onward.
- R8: The pending non-maskable flag is cleared at the end of the second vector cycle of every entry. An edge first seen in either vector cycle is lost and starts no entry.
- R9: A mask change by `ev_sei` or `ev_cli` does not apply to the poll that ends the same instruction or to the poll of the following instruction. It applies from the instruction after that.
- R10: On the `op_last` cycle of a return (`ev_rti`), the poll already uses `rti_ival` as the mask.
- R11: `int_ack` is high for exactly one cycle per entry, in the second vector cycle.
- R12: While an entry runs, `op_last`, `op_branch`, `br_poll`, `ev_sei`, `ev_cli`, `ev_rti` and `rti_ival` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| op_last | input | 1 | Last cycle of the current instruction |
| op_branch | input | 1 | Current instruction is a conditional branch |
| br_poll | input | 1 | Second cycle of a branch |
| ev_sei | input | 1 | Mask-set instruction in its last cycle |
| ev_cli | input | 1 | Mask-clear instruction in its last cycle |
| ev_rti | input | 1 | Return-from-interrupt in its last cycle |
| rti_ival | input | 1 | Mask value restored by the return |
| opc_force | output | 1 | Replace the fetched opcode with a break opcode |
| push_pch | output | 1 | Push return address high byte |
| push_pcl | output | 1 | Push return address low byte |
| push_stat | output | 1 | Push status with break flag clear |
| vec_en | output | 1 | Vector read cycle |
| vec_addr | output | 16 | Vector byte address |
| set_iflag | output | 1 | Set the mask flag in the status register |
| int_ack | output | 1 | Entry acknowledge, final vector read |

## Verification
The hardest overlap is a new non-maskable edge that lands in the same cycle as the automatic clear of the pending flag. A second case is an edge that lands just before the vector choice. The bench places a pulse on `nmi_n` relative to the entry phase, once in the push-low cycle and once in the first vector cycle. It then judges by the vector address read back and by whether any later entry happens while the mask is set. A second overlap, a request rising during a branch after its poll, is judged by counting entries at the end of the branch and at the end of the instruction that follows it.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_DUMMY = 3'd2,
    PH_PCH   = 3'd3,
    PH_PCL   = 3'd4,
    PH_STAT  = 3'd5,
    PH_VLO   = 3'd6,
    PH_VHI   = 3'd7
  } entry_ph_t;

  // advance the entry phase; idle leaves only on a take
  function automatic entry_ph_t ph_next(entry_ph_t cur, logic go);
    if (cur == PH_IDLE) return go ? PH_FETCH : PH_IDLE;
    if (cur == PH_VHI)  return PH_IDLE;
    return entry_ph_t'(cur + 3'd1);
  endfunction

  // vector byte address: base of the chosen source, plus one for the high byte
  function automatic logic [15:0] vec_pick(logic use_nmi, logic hi_byte,
                                           logic [15:0] nmi_base, logic [15:0] irq_base);
    logic [15:0] b;
    b = use_nmi ? nmi_base : irq_base;
    return b | {15'd0, hi_byte};
  endfunction

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic clear,
  output logic pend
);
  logic prev_q;
  logic fall_seen;

  assign fall_seen = prev_q & ~nmi_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      pend   <= clear ? 1'b0 : (pend | fall_seen);
    end
  end

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clear) |=> pend); // R4
  AST_NMI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pend); // R8
endmodule

// File: rtl/mask_tracker.sv
module mask_tracker #(
  parameter logic RESET_MASK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic sei,
  input  logic cli,
  input  logic rti,
  input  logic rti_val,
  input  logic force_set,
  input  logic flush,
  output logic poll_mask
);
  logic mask_q;
  logic lag_v;
  logic lag_val;

  // a return restores the mask in time for its own closing poll
  assign poll_mask = (boundary && rti) ? rti_val : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= RESET_MASK;
      lag_v   <= 1'b0;
      lag_val <= 1'b0;
    end else begin
      if (force_set) begin
        mask_q <= 1'b1;
      end else if (boundary) begin
        if (rti)        mask_q <= rti_val;
        else if (lag_v) mask_q <= lag_val;
        lag_v   <= sei | cli;
        lag_val <= sei;
      end
      if (flush) lag_v <= 1'b0;
    end
  end

  AST_SEI_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && (sei || cli) && !lag_v && !rti) |=> $stable(mask_q)); // R9
  AST_RTI_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && rti) |=> (mask_q == $past(rti_val))); // R10
endmodule

// File: rtl/int_poll.sv
module int_poll (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic op_last,
  input  logic op_branch,
  input  logic br_poll,
  input  logic nmi_pend,
  input  logic irq_n,
  input  logic poll_mask,
  output logic take
);
  logic want;
  logic poll_pt;
  logic arm_q;

  assign want    = nmi_pend | (~irq_n & ~poll_mask);
  assign poll_pt = ~busy & ((op_last & ~op_branch) | br_poll);
  assign take    = ~busy & op_last & ((poll_pt & want) | (op_branch & arm_q & ~br_poll));

  // branch decision is held from its second cycle to its last
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               arm_q <= 1'b0;
    else if (busy || op_last) arm_q <= 1'b0;
    else if (br_poll)         arm_q <= want;
  end

  AST_ARM_FROM_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !br_poll) |-> $past(arm_q || br_poll)); // R3
endmodule

// File: rtl/entry_stepper.sv
module entry_stepper
  import intseq_pkg::*;
#(
  parameter logic [15:0] VEC_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        nmi_pend,
  output logic        busy,
  output logic        opc_force,
  output logic        push_pch,
  output logic        push_pcl,
  output logic        push_stat,
  output logic        vec_en,
  output logic [15:0] vec_addr,
  output logic        set_iflag,
  output logic        int_ack
);
  entry_ph_t ph_q;
  logic      vnmi_q;
  logic      use_nmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      vnmi_q <= 1'b0;
    end else begin
      ph_q <= ph_next(ph_q, take);
      if (ph_q == PH_VLO) vnmi_q <= nmi_pend;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign opc_force = (ph_q == PH_FETCH);
  assign push_pch  = (ph_q == PH_PCH);
  assign push_pcl  = (ph_q == PH_PCL);
  assign push_stat = (ph_q == PH_STAT);
  assign vec_en    = (ph_q == PH_VLO) || (ph_q == PH_VHI);
  assign set_iflag = (ph_q == PH_VLO);
  assign int_ack   = (ph_q == PH_VHI);
  assign use_nmi   = (ph_q == PH_VLO) ? nmi_pend : vnmi_q;
  assign vec_addr  = vec_en ? vec_pick(use_nmi, ph_q == PH_VHI, VEC_NMI, VEC_IRQ) : 16'h0000;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({opc_force, push_pch, push_pcl, push_stat, vec_en})); // R2
  AST_DUMMY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    opc_force |=> (!opc_force && !push_pch && busy)); // R2
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    push_pch |=> push_pcl); // R2
  AST_STAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    push_pcl |=> push_stat); // R2
  AST_VEC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_stat |=> (vec_en && !vec_addr[0])); // R6
  AST_VEC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en && !vec_addr[0]) |=> (int_ack && vec_addr[0] && $stable(vec_addr[15:1]))); // R11
endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl #(
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter logic        RESET_MASK = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_n,
  input  logic        nmi_n,
  input  logic        op_last,
  input  logic        op_branch,
  input  logic        br_poll,
  input  logic        ev_sei,
  input  logic        ev_cli,
  input  logic        ev_rti,
  input  logic        rti_ival,
  output logic        opc_force,
  output logic        push_pch,
  output logic        push_pcl,
  output logic        push_stat,
  output logic        vec_en,
  output logic [15:0] vec_addr,
  output logic        set_iflag,
  output logic        int_ack
);
  // named internal events
  logic busy;
  logic take;
  logic nmi_pend;
  logic poll_mask;
  logic boundary;

  assign boundary = op_last & ~busy;

  nmi_edge_latch u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .nmi_n (nmi_n),
    .clear (int_ack),
    .pend  (nmi_pend)
  );

  mask_tracker #(.RESET_MASK(RESET_MASK)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .sei       (ev_sei),
    .cli       (ev_cli),
    .rti       (ev_rti),
    .rti_val   (rti_ival),
    .force_set (set_iflag),
    .flush     (take),
    .poll_mask (poll_mask)
  );

  int_poll u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .op_last   (op_last),
    .op_branch (op_branch),
    .br_poll   (br_poll),
    .nmi_pend  (nmi_pend),
    .irq_n     (irq_n),
    .poll_mask (poll_mask),
    .take      (take)
  );

  entry_stepper #(.VEC_NMI(VEC_NMI), .VEC_IRQ(VEC_IRQ)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .nmi_pend  (nmi_pend),
    .busy      (busy),
    .opc_force (opc_force),
    .push_pch  (push_pch),
    .push_pcl  (push_pcl),
    .push_stat (push_stat),
    .vec_en    (vec_en),
    .vec_addr  (vec_addr),
    .set_iflag (set_iflag),
    .int_ack   (int_ack)
  );

  AST_TAKE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> opc_force); // R2
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !take); // R12
  AST_SETI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    set_iflag |=> poll_mask); // R7
  AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !nmi_pend); // R8
endmodule

// File: tb/irq_entry_ctl_bench.sv
`timescale 1ns/1ps
module irq_entry_ctl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic irq_n, nmi_n, op_last, op_branch, br_poll, ev_sei, ev_cli, ev_rti, rti_ival;
  logic opc_force, push_pch, push_pcl, push_stat, vec_en, set_iflag, int_ack;
  logic [15:0] vec_addr;

  irq_entry_ctl u_irq_entry_ctl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n), .op_last(op_last),
    .op_branch(op_branch), .br_poll(br_poll), .ev_sei(ev_sei), .ev_cli(ev_cli),
    .ev_rti(ev_rti), .rti_ival(rti_ival), .opc_force(opc_force), .push_pch(push_pch),
    .push_pcl(push_pcl), .push_stat(push_stat), .vec_en(vec_en), .vec_addr(vec_addr),
    .set_iflag(set_iflag), .int_ack(int_ack));

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  int entries = 0;
  logic [15:0] last_vec = 16'h0;
  bit done = 0;

  // reference state, rebuilt from the requirements
  int m_ph;
  bit m_pend, m_prev, m_mask, m_lagv, m_lagval, m_arm, m_vnmi;

  // stimulus controls
  bit irq_lvl = 0;
  int irq_idx = -1;
  int nlo_s = -1, nlo_e = -1;
  int nmi_at_ph = 0;
  bit junk = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, ncyc);
    end
  endtask

  function automatic logic [15:0] exp_vec(int ph, bit pend, bit vnmi);
    if (ph == 6) return pend ? 16'hFFFA : 16'hFFFE;
    if (ph == 7) return vnmi ? 16'hFFFB : 16'hFFFF;
    return 16'h0000;
  endfunction

  task automatic cyc(input bit ol, input bit ob, input bit bp, input bit s,
                     input bit c, input bit r, input bit ri);
    bit nv, iv, fall, meff, want, go;
    @(negedge clk);
    chk("R2 opc_force", opc_force, m_ph == 1);
    chk("R2 push_pch",  push_pch,  m_ph == 3);
    chk("R2 push_pcl",  push_pcl,  m_ph == 4);
    chk("R2 push_stat", push_stat, m_ph == 5);
    chk("R6 vec_en",    vec_en,    m_ph >= 6);
    chk("R6 vec_addr",  vec_addr,  exp_vec(m_ph, m_pend, m_vnmi));
    chk("R7 set_iflag", set_iflag, m_ph == 6);
    chk("R11 int_ack",  int_ack,   m_ph == 7);
    if (opc_force) entries++;
    if (vec_en && !vec_addr[0]) last_vec = vec_addr;
    if (nmi_at_ph != 0 && m_ph == nmi_at_ph) begin
      nlo_s = ncyc; nlo_e = ncyc + 3; nmi_at_ph = 0;
    end
    nv = !(ncyc >= nlo_s && ncyc < nlo_e);
    iv = irq_lvl;
    if (m_ph != 0 && junk) begin  // R12: garbage status while the entry runs
      ol = 1'($urandom); ob = 1'($urandom); bp = 1'($urandom); s = 1'($urandom);
      c = 1'($urandom); r = 1'($urandom); ri = 1'($urandom);
    end
    irq_n = !iv; nmi_n = nv; op_last = ol; op_branch = ob; br_poll = bp;
    ev_sei = s; ev_cli = c; ev_rti = r; rti_ival = ri;
    // reference step
    fall = m_prev && !nv;
    m_prev = nv;
    if (m_ph != 0) begin
      if (m_ph == 6) begin m_vnmi = m_pend; m_mask = 1; end
      m_pend = (m_ph == 7) ? 1'b0 : (m_pend | fall);
      m_arm = 0;
      m_ph = (m_ph == 7) ? 0 : m_ph + 1;
    end else begin
      meff = (ol && r) ? ri : m_mask;
      want = m_pend || (iv && !meff);
      go = ol && ((!ob && want) || (ob && (bp ? want : m_arm)));
      if (ol) m_arm = 0; else if (bp) m_arm = want;
      if (ol) begin
        if (r) m_mask = ri; else if (m_lagv) m_mask = m_lagval;
        m_lagv = s | c; m_lagval = s;
      end
      m_pend = m_pend | fall;
      if (go) begin m_ph = 1; m_lagv = 0; end
    end
    ncyc++;
  endtask

  // kind: 0 plain, 1 branch, 2 mask-set, 3 mask-clear, 4 return
  task automatic insn(input int kind, input int len, input bit rv = 0);
    while (m_ph != 0) cyc(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < len; i++) begin
      bit last;
      last = (i == len - 1);
      if (i == irq_idx) begin irq_lvl = 1; irq_idx = -1; end
      cyc(last, kind == 1, kind == 1 && i == 1, last && kind == 2,
          last && kind == 3, last && kind == 4, rv);
    end
  endtask

  task automatic drain();
    repeat (8) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; irq_n = 1; nmi_n = 1; op_last = 0; op_branch = 0; br_poll = 0;
    ev_sei = 0; ev_cli = 0; ev_rti = 0; rti_ival = 0;
    m_ph = 0; m_pend = 0; m_prev = 1; m_mask = 1; m_lagv = 0; m_lagval = 0; m_arm = 0; m_vnmi = 0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset",
        {opc_force, push_pch, push_pcl, push_stat, vec_en, set_iflag, int_ack}, 0);
    chk("R1 vec_addr in reset", vec_addr, 16'h0);
    rst_n = 1;

    // R1 / R5: mask set out of reset, request held low is ignored
    irq_lvl = 1;
    insn(0, 3); insn(0, 3); insn(0, 3); drain();
    chk("R5 no entry while masked", entries, 0);

    // R9: clear lags one instruction
    insn(3, 2); drain();
    chk("R9 no entry at end of clear", entries, 0);
    insn(0, 2); drain();
    chk("R9 no entry after next instruction", entries, 0);
    insn(0, 2); drain();
    chk("R9 entry one instruction later", entries, 1);
    chk("R6 maskable vector", last_vec, 16'hFFFE);

    // R10: return restoring an open mask is polled at once
    insn(4, 6, 0); drain();
    chk("R10 entry right after return", entries, 2);
    irq_lvl = 0;
    insn(4, 6, 1); irq_lvl = 1; insn(0, 2); insn(0, 2); drain();
    chk("R10 restored set mask blocks", entries, 2);

    // R3: request rising after the branch poll waits one instruction
    irq_lvl = 0;
    insn(4, 6, 0);
    irq_idx = 2; insn(1, 4); drain();
    chk("R3 late request not taken at branch end", entries, 2);
    insn(0, 3); drain();
    chk("R3 taken after following instruction", entries, 3);
    irq_lvl = 0;
    insn(4, 6, 0);
    irq_idx = 0; insn(1, 4); drain();
    chk("R3 early request taken at branch end", entries, 4);

    // R4: both pending picks the edge request; held low fires once
    irq_lvl = 0;
    insn(4, 6, 0);
    irq_lvl = 1; nlo_s = ncyc; nlo_e = ncyc + 100000;
    insn(0, 2); drain();
    chk("R4 priority entry", entries, 5);
    chk("R4 edge vector wins", last_vec, 16'hFFFA);
    insn(0, 2); insn(0, 2); insn(0, 2); drain();
    chk("R4 held low does not retrigger", entries, 5);
    nlo_e = ncyc;

    // R6 / R12: edge during pushes redirects; status noise ignored
    junk = 1;
    irq_lvl = 0;
    insn(4, 6, 0);
    irq_lvl = 1; nmi_at_ph = 4;
    insn(0, 2); drain();
    chk("R12 one entry despite noise", entries, 6);
    chk("R6 redirected to edge vector", last_vec, 16'hFFFA);
    insn(0, 2); insn(0, 2); drain();
    chk("R8 serviced edge not repeated", entries, 6);

    // R8: edge in first vector cycle is lost
    irq_lvl = 0;
    insn(4, 6, 0);
    irq_lvl = 1; nmi_at_ph = 6;
    insn(0, 2); drain();
    chk("R8 maskable vector kept", last_vec, 16'hFFFE);
    irq_lvl = 0;
    insn(0, 2); insn(0, 2); insn(0, 2); drain();
    chk("R8 late edge lost", entries, 7);

    // mixed random traffic checked cycle by cycle against the reference
    for (int n = 0; n < 900; n++) begin
      int k;
      k = $urandom % 10;
      if ($urandom % 4 == 0) irq_lvl = ~irq_lvl;
      if ($urandom % 10 == 0) begin
        nlo_s = ncyc + ($urandom % 6);
        nlo_e = nlo_s + 1 + ($urandom % 6);
      end
      if (k < 5)       insn(0, 2 + ($urandom % 6));
      else if (k < 7)  insn(1, 2 + ($urandom % 3));
      else if (k == 7) insn(2, 2);
      else if (k == 8) insn(3, 2);
      else             insn(4, 6, 1'($urandom));
    end
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule